// File: doc/BRIEF.md
# Guest Instruction Issue Gate

This block sits between a host that feeds guest instructions into an emulated processor one at a time and the guest execution unit. For each instruction the host hands over, the gate returns a registered instruction-type code that tells the host which handling path to take (arithmetic, load, store, branch, multiply/divide, coprocessor). The gate also keeps the guest program counter and a cycle budget.

The host loads the budget before it enters its dispatch loop. Each instruction that is issued normally costs one cycle of budget, and the host can take further latencies, such as a coprocessor's reported cost, off the budget through a subtract port. When the budget is exhausted or an interrupt is pending, the gate answers the next instruction with type code zero, and the host leaves its loop. An instruction in a branch delay slot is never refused. The stop is deferred to the first instruction after the slot. A refused instruction is not decoded and does not change the program counter or the budget. The program counter moves only by itself on normal issue, or by an explicit host write.

Top module: `issue_gate`

## Requirements
- R1: While reset is asserted and after it is released, `typeValid` is 0, `pcOut` equals the `RESET_PC` parameter (default 0) and `budgetOut` is 0.
- R2: On normal issue, the type code comes from opcode bits (`instrOpcode`) and function bits (`instrFunct`). Opcode 0 gives branch=4 for function 0x08/0x09, multiply/divide=5 for function 0x10..0x13 or 0x18..0x1B, and ALU=1 for any other function. Opcodes 0x01..0x07 give branch=4. Opcodes 0x10..0x13 give coprocessor=6. Opcodes 0x20..0x26 and 0x30..0x33 give load=2. Opcodes 0x28..0x2E and 0x38..0x3B give store=3. Any other opcode gives ALU=1.
- R3: An instruction is accepted on a rising edge where `instrValid` and `instrReady` are both high. At that same edge `typeValid` rises for exactly one cycle with the type code. On normal issue, `pcOut` advances by 4 and `budgetOut` drops by 1 at that edge.
- R4: When an instruction is accepted with a budget of 0 and it is not in a delay slot, the type code is 0, and `pcOut` and `budgetOut` keep their values (apart from any subtraction in that cycle).
- R5: When an instruction is accepted with `irqPending` high and it is not in a delay slot, the type code is 0 whatever the budget, and neither `pcOut` nor the budget decrement changes.
- R6: The instruction right after a normally issued branch (code 4) is in a delay slot. It is issued normally even if the budget is 0 or `irqPending` is high. The stop falls on the next instruction after it.
- R7: `pcWrEn` loads `pcWrData` into the program counter and `budLdEn` loads `budLdData` into the budget, each visible one cycle later. `instrReady` is low in any cycle where either write strobe is high.
- R8: `subEn` takes `subData` off the budget. If an issue decrement falls in the same cycle, both are taken off together. The budget stops at 0 and never wraps.
- R9: A delay-slot instruction issued with a budget of 0 leaves the budget at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pcWrEn | input | 1 | Host program counter write strobe |
| pcWrData | input | PC_W | Value written to the program counter |
| budLdEn | input | 1 | Host budget load strobe |
| budLdData | input | BUD_W | Budget value loaded |
| subEn | input | 1 | Budget subtraction strobe |
| subData | input | BUD_W | Cycles to take off the budget |
| irqPending | input | 1 | Interrupt pending status |
| instrValid | input | 1 | Host presents an instruction |
| instrReady | output | 1 | Gate can accept an instruction |
| instrOpcode | input | 6 | Primary opcode field of the instruction |
| instrFunct | input | 6 | Function field of the instruction |
| typeValid | output | 1 | Type code valid for one cycle |
| typeCode | output | 3 | Instruction type, 0 means leave the dispatch loop |
| pcOut | output | PC_W | Guest program counter |
| budgetOut | output | BUD_W | Remaining cycle budget |

## Verification
The two functions that share a cycle are the issue decrement and the host subtraction. Both write the budget register, and their sum can pass the remaining budget. The bench provokes this by presenting an instruction with `subEn` high, once with enough budget, where the expected result is the budget minus the subtracted value minus one, and once during a refused instruction at zero budget, where the budget must stay 0. Delay-slot deferral is judged in the same way: a branch is followed by a slot instruction that has an interrupt pending or a budget of zero, and the slot must get a normal code while the instruction after it gets code zero.

// File: rtl/issue_gate_pkg.sv
package issue_gate_pkg;

  localparam int TYPE_W = 3;
  localparam int FIELD_W = 6;

  typedef enum logic [TYPE_W-1:0] {
    T_STOP   = 3'd0,
    T_ALU    = 3'd1,
    T_LOAD   = 3'd2,
    T_STORE  = 3'd3,
    T_BRANCH = 3'd4,
    T_MULDIV = 3'd5,
    T_COP    = 3'd6
  } itype_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   issueRun;   // normal issue: advance pc, spend one cycle
    logic   issueHalt;  // refused issue: report stop code only
    itype_e code;       // code to register
    logic   pcLoad;
    logic   budLoad;
    logic   subtract;
  } strobe_t;

endpackage

// File: rtl/issue_gate_decode.sv
module issue_gate_decode
  import issue_gate_pkg::*;
(
  input  logic [FIELD_W-1:0] opcode,
  input  logic [FIELD_W-1:0] funct,
  output itype_e             code
);

  always_comb begin
    code = T_ALU;
    if (opcode == 6'h00) begin
      case (funct) inside
        6'h08, 6'h09:                code = T_BRANCH;
        [6'h10:6'h13], [6'h18:6'h1B]: code = T_MULDIV;
        default:                     code = T_ALU;
      endcase
    end else begin
      case (opcode) inside
        [6'h01:6'h07]:                code = T_BRANCH;
        [6'h10:6'h13]:                code = T_COP;
        [6'h20:6'h26], [6'h30:6'h33]: code = T_LOAD;
        [6'h28:6'h2E], [6'h38:6'h3B]: code = T_STORE;
        default:                     code = T_ALU;
      endcase
    end
  end

endmodule

// File: rtl/issue_gate_ctrl.sv
module issue_gate_ctrl
  import issue_gate_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    pcWrEn,
  input  logic    budLdEn,
  input  logic    subEn,
  input  logic    instrValid,
  input  logic    irqPending,
  input  logic    budgetZero,
  input  itype_e  decCode,
  output logic    instrReady,
  output strobe_t strb
);

  logic slotQ;
  logic accept;
  logic haltCond;

  // host register writes take the cycle, so instructions wait
  assign instrReady = !(pcWrEn || budLdEn);
  assign accept     = instrValid && instrReady;
  // a delay slot is never refused: the stop waits one more instruction
  assign haltCond   = (budgetZero || irqPending) && !slotQ;

  always_comb begin
    strb           = '0;
    strb.issueRun  = accept && !haltCond;
    strb.issueHalt = accept && haltCond;
    strb.code      = strb.issueRun ? decCode : T_STOP;
    strb.pcLoad    = pcWrEn;
    strb.budLoad   = budLdEn;
    strb.subtract  = subEn && !budLdEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotQ <= 1'b0;
    end else if (strb.issueRun) begin
      slotQ <= (decCode == T_BRANCH);
    end
  end

endmodule

// File: rtl/issue_gate_dp.sv
module issue_gate_dp
  import issue_gate_pkg::*;
#(
  parameter int          PC_W     = 32,
  parameter int          BUD_W    = 16,
  parameter logic [31:0] RESET_PC = 32'h0,
  parameter int          PC_STEP  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [PC_W-1:0]   pcWrData,
  input  logic [BUD_W-1:0]  budLdData,
  input  logic [BUD_W-1:0]  subData,
  output logic              budgetZero,
  output logic              typeValid,
  output itype_e            typeCode,
  output logic [PC_W-1:0]   pcOut,
  output logic [BUD_W-1:0]  budgetOut
);

  localparam int SUM_W = BUD_W + 1;

  logic [SUM_W-1:0] takeSum;
  logic [BUD_W-1:0] budNext;

  // subtraction and issue decrement are combined, then clipped at zero
  always_comb begin
    takeSum = SUM_W'(strb.subtract ? subData : '0) + SUM_W'(strb.issueRun);
    if ({1'b0, budgetOut} <= takeSum) begin
      budNext = '0;
    end else begin
      budNext = budgetOut - takeSum[BUD_W-1:0];
    end
  end

  assign budgetZero = (budgetOut == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcOut     <= RESET_PC[PC_W-1:0];
      budgetOut <= '0;
      typeValid <= 1'b0;
      typeCode  <= T_STOP;
    end else begin
      if (strb.pcLoad) begin
        pcOut <= pcWrData;
      end else if (strb.issueRun) begin
        pcOut <= pcOut + PC_W'(PC_STEP);
      end
      if (strb.budLoad) begin
        budgetOut <= budLdData;
      end else begin
        budgetOut <= budNext;
      end
      typeValid <= strb.issueRun || strb.issueHalt;
      typeCode  <= strb.code;
    end
  end

endmodule

// File: rtl/issue_gate.sv
module issue_gate
  import issue_gate_pkg::*;
#(
  parameter int          PC_W     = 32,
  parameter int          BUD_W    = 16,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pcWrEn,
  input  logic [PC_W-1:0]    pcWrData,
  input  logic               budLdEn,
  input  logic [BUD_W-1:0]   budLdData,
  input  logic               subEn,
  input  logic [BUD_W-1:0]   subData,
  input  logic               irqPending,
  input  logic               instrValid,
  output logic               instrReady,
  input  logic [5:0]         instrOpcode,
  input  logic [5:0]         instrFunct,
  output logic               typeValid,
  output logic [2:0]         typeCode,
  output logic [PC_W-1:0]    pcOut,
  output logic [BUD_W-1:0]   budgetOut
);

  itype_e  decCode;
  itype_e  codeQ;
  strobe_t strb;
  logic    budgetZero;

  issue_gate_decode u_decode (
    .opcode (instrOpcode),
    .funct  (instrFunct),
    .code   (decCode)
  );

  issue_gate_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .pcWrEn     (pcWrEn),
    .budLdEn    (budLdEn),
    .subEn      (subEn),
    .instrValid (instrValid),
    .irqPending (irqPending),
    .budgetZero (budgetZero),
    .decCode    (decCode),
    .instrReady (instrReady),
    .strb       (strb)
  );

  issue_gate_dp #(
    .PC_W     (PC_W),
    .BUD_W    (BUD_W),
    .RESET_PC (RESET_PC)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .pcWrData   (pcWrData),
    .budLdData  (budLdData),
    .subData    (subData),
    .budgetZero (budgetZero),
    .typeValid  (typeValid),
    .typeCode   (codeQ),
    .pcOut      (pcOut),
    .budgetOut  (budgetOut)
  );

  assign typeCode = codeQ;

endmodule

// File: rtl/issue_gate_chk.sv
module issue_gate_chk #(
  parameter int PC_W  = 32,
  parameter int BUD_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             pcWrEn,
  input logic             budLdEn,
  input logic             instrValid,
  input logic             instrReady,
  input logic             typeValid,
  input logic [2:0]       typeCode,
  input logic [PC_W-1:0]  pcOut,
  input logic [BUD_W-1:0] budgetOut
);

  a_r7_ready_low: assert property (@(posedge clk) disable iff (!rstN)
    (pcWrEn || budLdEn) |-> !instrReady);

  a_r3_result_follows_accept: assert property (@(posedge clk) disable iff (!rstN)
    typeValid |-> $past(instrValid && instrReady));

  a_r3_pc_step: assert property (@(posedge clk) disable iff (!rstN)
    (typeValid && typeCode != 3'd0) |-> (pcOut == $past(pcOut) + PC_W'(4)));

  a_r4_stop_holds_pc: assert property (@(posedge clk) disable iff (!rstN)
    (typeValid && typeCode == 3'd0) |-> (pcOut == $past(pcOut)));

  a_r8_budget_no_growth: assert property (@(posedge clk) disable iff (!rstN)
    !$past(budLdEn) |-> (budgetOut <= $past(budgetOut)));

  a_r2_code_range: assert property (@(posedge clk) disable iff (!rstN)
    typeValid |-> (typeCode <= 3'd6));

endmodule

bind issue_gate issue_gate_chk #(.PC_W(PC_W), .BUD_W(BUD_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .pcWrEn     (pcWrEn),
  .budLdEn    (budLdEn),
  .instrValid (instrValid),
  .instrReady (instrReady),
  .typeValid  (typeValid),
  .typeCode   (typeCode),
  .pcOut      (pcOut),
  .budgetOut  (budgetOut)
);

// File: tb/issue_gate_tb.sv
module issue_gate_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pcWrEn = 1'b0;
  logic [31:0] pcWrData = '0;
  logic        budLdEn = 1'b0;
  logic [15:0] budLdData = '0;
  logic        subEn = 1'b0;
  logic [15:0] subData = '0;
  logic        irqPending = 1'b0;
  logic        instrValid = 1'b0;
  logic        instrReady;
  logic [5:0]  instrOpcode = '0;
  logic [5:0]  instrFunct = '0;
  logic        typeValid;
  logic [2:0]  typeCode;
  logic [31:0] pcOut;
  logic [15:0] budgetOut;

  always #5 clk = ~clk;

  issue_gate u_dut (
    .clk(clk), .rstN(rstN), .pcWrEn(pcWrEn), .pcWrData(pcWrData),
    .budLdEn(budLdEn), .budLdData(budLdData), .subEn(subEn), .subData(subData),
    .irqPending(irqPending), .instrValid(instrValid), .instrReady(instrReady),
    .instrOpcode(instrOpcode), .instrFunct(instrFunct), .typeValid(typeValid),
    .typeCode(typeCode), .pcOut(pcOut), .budgetOut(budgetOut)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    logic [2:0]  code;
    logic [31:0] pc;
    int          bud;
    string       req;
  } exp_t;

  exp_t        expQ[$];
  logic [31:0] mPc = 32'h0;
  int          mBud = 0;
  bit          mSlot = 0;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int sat0(int v);
    return (v < 0) ? 0 : v;
  endfunction

  // driver: present one instruction, model the expected outcome, queue it
  task automatic issue(logic [5:0] op, logic [5:0] fn, logic [2:0] code,
                       bit irq, int sub, string req);
    exp_t e;
    bit   halt;
    @(negedge clk);
    instrValid  = 1'b1;
    instrOpcode = op;
    instrFunct  = fn;
    irqPending  = irq;
    subEn       = (sub != 0);
    subData     = 16'(sub);
    halt = ((mBud == 0) || irq) && !mSlot;
    if (halt) begin
      e.code = 3'd0;
      mBud   = sat0(mBud - sub);
    end else begin
      e.code = code;
      mPc    = mPc + 32'd4;
      mBud   = sat0(mBud - sub - 1);
      mSlot  = (code == 3'd4);
    end
    e.pc  = mPc;
    e.bud = mBud;
    e.req = req;
    expQ.push_back(e);
    @(negedge clk);
    instrValid = 1'b0;
    subEn      = 1'b0;
    irqPending = 1'b0;
  endtask

  // monitor: compare each result as it appears
  always @(negedge clk) begin
    if (rstN && typeValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R3", "unexpected typeValid", 1, 0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check(typeCode == e.code, e.req, "typeCode", typeCode, e.code);
        check(pcOut == e.pc, e.req, "pcOut", pcOut, e.pc);
        check(budgetOut == 16'(e.bud), e.req, "budgetOut", budgetOut, e.bud);
      end
    end
  end

  task automatic loadBudget(int v);
    @(negedge clk);
    budLdEn = 1'b1;
    budLdData = 16'(v);
    #1 check(instrReady == 1'b0, "R7", "instrReady during budget load", instrReady, 0);
    @(negedge clk);
    budLdEn = 1'b0;
    mBud = v;
    check(budgetOut == 16'(v), "R7", "budget load", budgetOut, v);
  endtask

  task automatic writePc(logic [31:0] v);
    @(negedge clk);
    pcWrEn = 1'b1;
    pcWrData = v;
    #1 check(instrReady == 1'b0, "R7", "instrReady during pc write", instrReady, 0);
    @(negedge clk);
    pcWrEn = 1'b0;
    mPc = v;
    check(pcOut == v, "R7", "pc write", pcOut, v);
  endtask

  task automatic subtractOnly(int v);
    @(negedge clk);
    subEn = 1'b1;
    subData = 16'(v);
    @(negedge clk);
    subEn = 1'b0;
    mBud = sat0(mBud - v);
    check(budgetOut == 16'(mBud), "R8", "saturating subtract", budgetOut, mBud);
    check(typeValid == 1'b0, "R3", "no result without instruction", typeValid, 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(typeValid == 1'b0, "R1", "typeValid in reset", typeValid, 0);
    check(pcOut == 32'h0, "R1", "pcOut in reset", pcOut, 0);
    check(budgetOut == 16'h0, "R1", "budgetOut in reset", budgetOut, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(typeValid == 1'b0 && budgetOut == 16'h0, "R1", "state after reset", budgetOut, 0);

    writePc(32'h100);
    loadBudget(20);

    // R2 decode classes, R3 normal issue
    issue(6'h00, 6'h21, 3'd1, 0, 0, "R2 alu");
    issue(6'h23, 6'h00, 3'd2, 0, 0, "R2 load");
    issue(6'h2B, 6'h00, 3'd3, 0, 0, "R2 store");
    issue(6'h00, 6'h18, 3'd5, 0, 0, "R2 multiply");
    issue(6'h00, 6'h10, 3'd5, 0, 0, "R2 hi/lo move");
    issue(6'h12, 6'h00, 3'd6, 0, 0, "R2 coprocessor");
    issue(6'h32, 6'h00, 3'd2, 0, 0, "R2 coprocessor load");
    issue(6'h3A, 6'h00, 3'd3, 0, 0, "R2 coprocessor store");
    issue(6'h09, 6'h00, 3'd1, 0, 0, "R2 immediate");
    issue(6'h00, 6'h08, 3'd4, 0, 0, "R2 register jump");
    issue(6'h00, 6'h21, 3'd1, 0, 0, "R3 slot alu");
    issue(6'h01, 6'h00, 3'd4, 0, 0, "R2 regimm branch");
    issue(6'h0D, 6'h00, 3'd1, 0, 0, "R3 slot immediate");
    issue(6'h02, 6'h00, 3'd4, 0, 0, "R2 jump");
    issue(6'h0F, 6'h00, 3'd1, 0, 0, "R3 slot");

    // R8 subtraction and decrement in the same cycle: 5 - 3 - 1
    issue(6'h00, 6'h21, 3'd1, 0, 3, "R8 subtract with issue");
    subtractOnly(1000);

    // R4 zero budget stops
    issue(6'h00, 6'h21, 3'd1, 0, 0, "R4 stop at zero budget");
    issue(6'h00, 6'h21, 3'd1, 0, 5, "R8 subtract at zero budget");

    // R5 interrupt stops without spending
    loadBudget(3);
    issue(6'h23, 6'h00, 3'd2, 1, 0, "R5 irq stop");
    // R6 delay slot defers the stop
    issue(6'h04, 6'h00, 3'd4, 0, 0, "R6 branch");
    issue(6'h00, 6'h21, 3'd1, 1, 0, "R6 slot issues under irq");
    issue(6'h00, 6'h21, 3'd1, 1, 0, "R6 stop after slot");

    // R9 slot at zero budget
    loadBudget(1);
    issue(6'h05, 6'h00, 3'd4, 0, 0, "R6 branch spends last cycle");
    issue(6'h2B, 6'h00, 3'd3, 0, 0, "R9 slot at zero budget");
    issue(6'h00, 6'h21, 3'd1, 0, 0, "R4 stop after slot");

    // R7 redirect and resume
    writePc(32'h2000);
    loadBudget(2);
    issue(6'h00, 6'h1A, 3'd5, 0, 0, "R7 resume after redirect");

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R3", "results outstanding", expQ.size(), 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule